// File: doc/BRIEF.md
# Token-Sequenced I2C Master

This block is an I2C bus master that plays back a preloaded list of command tokens instead of waiting for software between bytes. Software fills a sixteen-entry list of 4-bit tokens, up to eight bytes of outgoing data and the target address. It then raises a launch bit. The sequencer steps through the list, driving START and STOP conditions, address bytes and data bytes on open-drain SCL/SDA lines. Received bytes are packed into two read words. When the run ends, a one-cycle interrupt pulse is raised.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no valid/ready handshake and never applies back-pressure. Every write takes effect on the clock edge where the strobe is high. Reads reflect state in the same cycle. The bus pins are modelled as active-high "pull low" enables plus sampled line levels. Between runs the bus stays owned until a STOP token is executed, so one transaction can be split over several runs.

Top module: `i2ctok_master`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, neither bus line is pulled low, and the interrupt is low.
- R2: A run starts only on a register write that takes control bit 0 from 0 to 1. Writing 1 while bit 0 is already 1 starts nothing. Control bit 2 (busy) reads 1 while a run is active.
- R3: Tokens are END=0, START=1, ADDR_WRITE=2, ADDR_READ=3, DATA=4, DATA_LAST=5, STOP=6. Slot n sits at bits [4n+3:4n] of list word 0x08 for n<8, and at bits [4(n-8)+3:4(n-8)] of word 0x0C otherwise. Slots execute from 0 upward. A run ends at an END token or after slot 15. At that point busy clears and the interrupt is high for exactly one cycle.
- R4: The slave-address register (0x04) holds the 7-bit address in bits [7:1]. ADDR_WRITE sends those bits with bit 0 forced to 0, and ADDR_READ sends them with bit 0 forced to 1. The direction chosen by the latest address token stays in force across later runs.
- R5: In write direction, each DATA or DATA_LAST token sends the next byte. Byte k lives at bits [8(k%4)+7:8(k%4)] of word 0x10 (k<4) or 0x14 (k≥4). The byte index restarts at 0 each run and wraps to 0 after byte 7.
- R6: In read direction, DATA receives a byte and answers ACK, and DATA_LAST receives a byte and answers NACK. The byte is stored at position k of read words 0x18/0x1C, using the same packing as R5.
- R7: With control bit 1 (ack-ignore) clear, a NACK on an address or written byte sets control bit 3 (error), generates a STOP, and ends the run. Starting a new run clears bit 3.
- R8: With ack-ignore set, a NACK is ignored: the list continues and bit 3 stays 0.
- R9: Control bits [21:12] hold the divider D. One quarter bit lasts max(D,1) clocks, so SCL stays released for 2·max(D,1) clocks per bit.
- R10: Writing 0 to control bit 0 during a run stops it at once: busy clears, both lines are released, and no interrupt follows.
- R11: A run that ends without STOP leaves SCL pulled low. A later START token issues a repeated START.
- R12: During a byte, SDA changes only while SCL is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | One-cycle end-of-run pulse |

## Verification
The SDA-stability check assumes that software issues data tokens only while the bus is owned, meaning after a START in this or an earlier run. It also assumes the divider and the token list are not rewritten during a run. Every directed list in the bench begins a transaction with START, or continues one that was left held. Configuration writes happen only while the busy bit reads 0. The attached target model acknowledges one fixed address. Wrong addresses are used on purpose to produce NACKs.

// File: rtl/i2ctok_pkg.sv
`timescale 1ns/1ps
package i2ctok_pkg;
  localparam logic [3:0] TK_END       = 4'd0;
  localparam logic [3:0] TK_START     = 4'd1;
  localparam logic [3:0] TK_ADDR_W    = 4'd2;
  localparam logic [3:0] TK_ADDR_R    = 4'd3;
  localparam logic [3:0] TK_DATA      = 4'd4;
  localparam logic [3:0] TK_DATA_LAST = 4'd5;
  localparam logic [3:0] TK_STOP      = 4'd6;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE} op_e;
endpackage

// File: rtl/i2ctok_qtick.sv
`timescale 1ns/1ps
module i2ctok_qtick #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = run && (cnt >= lim - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + DIV_W'(1);
  end

  AST_QCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(div)) |-> (cnt < lim)); // R9
endmodule

// File: rtl/i2ctok_bitphy.sv
`timescale 1ns/1ps
module i2ctok_bitphy
  import i2ctok_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  op_e              op,
  input  logic [7:0]       tx_byte,
  input  logic             rx_mode,
  input  logic             master_ack,
  input  logic [DIV_W-1:0] div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             busy,
  output logic             done,
  output logic             nak,
  output logic [7:0]       rx_byte,
  output logic             scl_low,
  output logic             sda_low
);
  logic       tick;
  logic [1:0] qph;
  logic [3:0] bitn;
  logic [7:0] sh;
  op_e        op_q;
  logic       rx_q, mack_q;

  i2ctok_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
  );

  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; nak <= 1'b0;
      qph <= '0; bitn <= '0; sh <= '0; op_q <= OP_START;
      rx_q <= 1'b0; mack_q <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
      end else if (!busy) begin
        if (go) begin
          busy <= 1'b1; op_q <= op; qph <= '0; bitn <= '0;
          sh <= tx_byte; rx_q <= rx_mode; mack_q <= master_ack;
        end
      end else if (tick) begin
        qph <= qph + 2'd1;
        unique case (op_q)
          OP_START: begin
            case (qph)
              2'd0:    sda_low <= 1'b0;
              2'd1:    scl_low <= 1'b0;
              2'd2:    sda_low <= 1'b1;
              default: begin scl_low <= 1'b1; busy <= 1'b0; done <= 1'b1; end
            endcase
          end
          OP_STOP: begin
            case (qph)
              2'd0:    sda_low <= 1'b1;
              2'd1:    scl_low <= 1'b0;
              2'd2:    sda_low <= 1'b0;
              default: begin busy <= 1'b0; done <= 1'b1; end
            endcase
          end
          default: begin
            case (qph)
              2'd0: sda_low <= (bitn == 4'd8) ? (rx_q && mack_q) : (!rx_q && !sh[7]);
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (!scl_in)            qph <= qph;
                else if (bitn == 4'd8)  nak <= sda_in;
                else                    sh  <= {sh[6:0], sda_in};
              end
              default: begin
                scl_low <= 1'b1;
                if (bitn == 4'd8) begin busy <= 1'b0; done <= 1'b1; end
                else bitn <= bitn + 4'd1;
              end
            endcase
          end
        endcase
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_BYTE && !scl_low && $past(busy && op_q == OP_BYTE && !scl_low))
      |-> $stable(sda_low)); // R12
endmodule

// File: rtl/i2ctok_master.sv
`timescale 1ns/1ps
module i2ctok_master
  import i2ctok_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int SLOTS = 16,
  parameter int BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  output logic        irq
);
  localparam int TOK_W         = 4;
  localparam int TOKS_PER_WORD = 32 / TOK_W;
  localparam int LIST_WORDS    = SLOTS / TOKS_PER_WORD;
  localparam int DATA_WORDS    = BYTES / 4;
  localparam int SLOT_IW       = $clog2(SLOTS);
  localparam int BYTE_IW       = $clog2(BYTES);
  localparam int DIV_LSB       = 12;
  localparam int ADR_CTRL = 0, ADR_SADDR = 4, ADR_LIST = 8, ADR_WDAT = 16, ADR_RDAT = 24;

  typedef enum logic [2:0] {SQ_IDLE, SQ_FETCH, SQ_WAIT, SQ_ASTOP, SQ_AWAIT} seq_e;

  logic             ctrl_go_q, ack_ign_q, busy_q, err_q, rd_dir_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       saddr_q;
  logic [TOK_W-1:0] tok_q   [SLOTS];
  logic [7:0]       wbyte_q [BYTES];
  logic [7:0]       rbyte_q [BYTES];
  seq_e             st;
  logic [SLOT_IW-1:0] slot;
  logic [BYTE_IW-1:0] bidx;

  logic       wr_ctrl, go_rise, abort_req, last_slot, is_data, is_addr;
  logic [3:0] cur_tok;
  logic       phy_go, phy_rx, phy_mack, phy_busy, phy_done, phy_nak;
  op_e        phy_op;
  logic [7:0] phy_tx, phy_rx_byte;

  assign wr_ctrl   = reg_we && (reg_addr == 5'(ADR_CTRL));
  assign go_rise   = wr_ctrl && reg_wdata[0] && !ctrl_go_q;
  assign abort_req = wr_ctrl && !reg_wdata[0] && busy_q;
  assign cur_tok   = tok_q[slot];
  assign last_slot = (slot == SLOT_IW'(SLOTS - 1));
  assign is_data   = (cur_tok == TK_DATA) || (cur_tok == TK_DATA_LAST);
  assign is_addr   = (cur_tok == TK_ADDR_W) || (cur_tok == TK_ADDR_R);

  always_comb begin
    phy_go   = 1'b0;
    phy_op   = OP_BYTE;
    phy_tx   = wbyte_q[bidx];
    phy_rx   = rd_dir_q;
    phy_mack = (cur_tok == TK_DATA);
    if (st == SQ_ASTOP) begin
      phy_go = 1'b1; phy_op = OP_STOP;
    end else if (st == SQ_FETCH) begin
      case (cur_tok)
        TK_START:             begin phy_go = 1'b1; phy_op = OP_START; end
        TK_STOP:              begin phy_go = 1'b1; phy_op = OP_STOP; end
        TK_ADDR_W:            begin phy_go = 1'b1; phy_tx = {saddr_q[7:1], 1'b0}; phy_rx = 1'b0; end
        TK_ADDR_R:            begin phy_go = 1'b1; phy_tx = {saddr_q[7:1], 1'b1}; phy_rx = 1'b0; end
        TK_DATA, TK_DATA_LAST: phy_go = 1'b1;
        default: ;
      endcase
    end
  end

  i2ctok_bitphy #(.DIV_W(DIV_W)) u_phy (
    .clk(clk), .rst_n(rst_n), .abort(abort_req), .go(phy_go), .op(phy_op),
    .tx_byte(phy_tx), .rx_mode(phy_rx), .master_ack(phy_mack), .div(div_q),
    .scl_in(scl_in), .sda_in(sda_in), .busy(phy_busy), .done(phy_done),
    .nak(phy_nak), .rx_byte(phy_rx_byte), .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_go_q <= 1'b0; ack_ign_q <= 1'b0; busy_q <= 1'b0; err_q <= 1'b0;
      rd_dir_q <= 1'b0; div_q <= '0; saddr_q <= '0; irq <= 1'b0;
      st <= SQ_IDLE; slot <= '0; bidx <= '0;
      for (int i = 0; i < SLOTS; i++) tok_q[i] <= '0;
      for (int i = 0; i < BYTES; i++) begin wbyte_q[i] <= '0; rbyte_q[i] <= '0; end
    end else begin
      irq <= 1'b0;
      if (reg_we) begin
        if (wr_ctrl) begin
          ctrl_go_q <= reg_wdata[0];
          ack_ign_q <= reg_wdata[1];
          div_q     <= reg_wdata[DIV_LSB +: DIV_W];
        end
        if (reg_addr == 5'(ADR_SADDR)) saddr_q <= reg_wdata[7:0];
        for (int w = 0; w < LIST_WORDS; w++)
          if (reg_addr == 5'(ADR_LIST + 4*w))
            for (int k = 0; k < TOKS_PER_WORD; k++)
              tok_q[w*TOKS_PER_WORD + k] <= reg_wdata[k*TOK_W +: TOK_W];
        for (int w = 0; w < DATA_WORDS; w++)
          if (reg_addr == 5'(ADR_WDAT + 4*w))
            for (int k = 0; k < 4; k++)
              wbyte_q[w*4 + k] <= reg_wdata[k*8 +: 8];
      end

      if (abort_req) begin
        st <= SQ_IDLE; busy_q <= 1'b0;
      end else begin
        case (st)
          SQ_IDLE: if (go_rise) begin
            st <= SQ_FETCH; busy_q <= 1'b1; err_q <= 1'b0; slot <= '0; bidx <= '0;
          end
          SQ_FETCH: begin
            if (cur_tok == TK_END) begin
              st <= SQ_IDLE; busy_q <= 1'b0; irq <= 1'b1;
            end else if (phy_go) begin
              st <= SQ_WAIT;
              if (cur_tok == TK_ADDR_W) rd_dir_q <= 1'b0;
              if (cur_tok == TK_ADDR_R) rd_dir_q <= 1'b1;
            end else if (last_slot) begin
              st <= SQ_IDLE; busy_q <= 1'b0; irq <= 1'b1;
            end else slot <= slot + SLOT_IW'(1);
          end
          SQ_WAIT: if (phy_done) begin
            if ((is_addr || (is_data && !rd_dir_q)) && phy_nak && !ack_ign_q) begin
              err_q <= 1'b1; st <= SQ_ASTOP;
            end else begin
              if (is_data) begin
                if (rd_dir_q) rbyte_q[bidx] <= phy_rx_byte;
                bidx <= bidx + BYTE_IW'(1);
              end
              if (last_slot) begin
                st <= SQ_IDLE; busy_q <= 1'b0; irq <= 1'b1;
              end else begin
                slot <= slot + SLOT_IW'(1); st <= SQ_FETCH;
              end
            end
          end
          SQ_ASTOP: st <= SQ_AWAIT;
          default: if (phy_done) begin
            st <= SQ_IDLE; busy_q <= 1'b0; irq <= 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 5'(ADR_CTRL))
      reg_rdata = {{(32-DIV_LSB-DIV_W){1'b0}}, div_q, {(DIV_LSB-4){1'b0}},
                   err_q, busy_q, ack_ign_q, ctrl_go_q};
    else if (reg_addr == 5'(ADR_SADDR))
      reg_rdata = {24'b0, saddr_q};
    for (int w = 0; w < LIST_WORDS; w++)
      if (reg_addr == 5'(ADR_LIST + 4*w))
        for (int k = 0; k < TOKS_PER_WORD; k++)
          reg_rdata[k*TOK_W +: TOK_W] = tok_q[w*TOKS_PER_WORD + k];
    for (int w = 0; w < DATA_WORDS; w++) begin
      if (reg_addr == 5'(ADR_WDAT + 4*w))
        for (int k = 0; k < 4; k++) reg_rdata[k*8 +: 8] = wbyte_q[w*4 + k];
      if (reg_addr == 5'(ADR_RDAT + 4*w))
        for (int k = 0; k < 4; k++) reg_rdata[k*8 +: 8] = rbyte_q[w*4 + k];
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R3
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy_q && $past(busy_q))); // R3
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy_q && !scl_drive_low && !sda_drive_low && !irq)); // R10
  AST_ERR_STRICT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !ack_ign_q); // R7
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    phy_busy |-> busy_q); // R2
endmodule

// File: tb/i2ctok_master_tb.sv
`timescale 1ns/1ps
module i2ctok_master_tb_top;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dut_scl_low, dut_sda_low, irq;
  logic drv = 1'b0;
  logic scl_bus, sda_bus;
  int nchk = 0, nbad = 0, irq_cnt = 0;

  // target model state
  int st = 0, cnt = 0, starts = 0, stops = 0, acks = 0, nacks = 0, wn = 0, rk = 0;
  logic [7:0] sh = '0, rbyte = '0;
  logic rw = 1'b0, matched = 1'b0, mack = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] wlog [0:63];

  assign scl_bus = !dut_scl_low;
  assign sda_bus = !(dut_sda_low || drv);

  always #5 clk = !clk;

  i2ctok_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(dut_scl_low), .sda_drive_low(dut_sda_low), .irq(irq)
  );

  always @(posedge clk) if (irq) irq_cnt++;

  // behavioural target: st 0 idle, 1 address, 2 written-to, 3 read-from
  always @(scl_bus or sda_bus) begin
    if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
      starts++; cnt = -1; st = 1; drv = 1'b0;
    end else if (scl_bus && prev_scl && !prev_sda && sda_bus) begin
      stops++; st = 0; drv = 1'b0;
    end else if (scl_bus && !prev_scl) begin
      if ((st == 1 || st == 2) && cnt >= 0 && cnt < 8) sh = {sh[6:0], sda_bus};
      if (st == 3 && cnt == 8) begin
        mack = !sda_bus;
        if (mack) acks++; else nacks++;
      end
    end else if (!scl_bus && prev_scl) begin
      cnt++;
      if (st == 1) begin
        if (cnt == 8) begin
          matched = (sh[7:1] == SLV); rw = sh[0]; drv = matched;
        end else if (cnt == 9) begin
          cnt = 0; drv = 1'b0;
          if (!matched) st = 0;
          else if (rw) begin st = 3; rk = 0; rbyte = 8'hA0; drv = !rbyte[7]; end
          else st = 2;
        end
      end else if (st == 2) begin
        if (cnt == 8) begin wlog[wn] = sh; wn++; drv = 1'b1; end
        else if (cnt == 9) begin cnt = 0; drv = 1'b0; end
      end else if (st == 3) begin
        if (cnt >= 1 && cnt <= 7) drv = !rbyte[7-cnt];
        else if (cnt == 8) drv = 1'b0;
        else if (cnt == 9) begin
          cnt = 0;
          if (mack) begin rk++; rbyte = 8'hA0 + 8'(rk); drv = !rbyte[7]; end
          else begin st = 0; drv = 1'b0; end
        end
      end
    end
    prev_scl = scl_bus; prev_sda = sda_bus;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic launch(input logic [31:0] cfg);
    logic [31:0] c;
    reg_write(5'h00, cfg & ~32'h1);
    reg_write(5'h00, cfg | 32'h1);
    reg_read(5'h00, c);
    chk("R2 busy after launch", {31'b0, c[2]}, 32'h1);
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!irq && n < 30000) begin @(negedge clk); n++; end
    chk({tag, " irq seen"}, {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R3 irq one cycle", {31'b0, irq}, 32'h0);
  endtask

  localparam logic [31:0] DIV2 = 32'd2 << 12;

  task automatic t_reset;
    logic [31:0] c;
    reg_read(5'h00, c);
    chk("R1 ctrl reset", c, 32'h0);
    chk("R1 lines released", {30'b0, dut_scl_low, dut_sda_low}, 32'h0);
    chk("R1 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_write;
    logic [31:0] c; int w0 = wn, s0 = stops;
    reg_write(5'h04, {24'b0, SLV, 1'b0});
    reg_write(5'h08, 32'h00644421);
    reg_write(5'h10, 32'h00332211);
    launch(DIV2);
    wait_end("R3 write run");
    chk("R5 bytes sent", 32'(wn - w0), 32'd3);
    chk("R5 byte0", {24'b0, wlog[w0]}, 32'h11);
    chk("R5 byte1", {24'b0, wlog[w0+1]}, 32'h22);
    chk("R5 byte2", {24'b0, wlog[w0+2]}, 32'h33);
    chk("R3 stop seen", 32'(stops - s0), 32'd1);
    reg_read(5'h00, c);
    chk("R3 busy clear", {31'b0, c[2]}, 32'h0);
    chk("R3 lines released", {30'b0, dut_scl_low, dut_sda_low}, 32'h0);
  endtask

  task automatic t_read_restart;
    logic [31:0] r; int w0 = wn, a0 = acks, n0 = nacks, s0 = starts;
    reg_write(5'h08, 32'h54431421);
    reg_write(5'h0C, 32'h00000006);
    reg_write(5'h10, 32'h00000055);
    launch(DIV2);
    wait_end("R6 read run");
    chk("R5 write before restart", {24'b0, wlog[w0]}, 32'h55);
    chk("R11 repeated start count", 32'(starts - s0), 32'd2);
    reg_read(5'h18, r);
    chk("R6 read bytes 1..3", {8'b0, r[31:8]}, 32'h00A2A1A0);
    reg_read(5'h1C, r);
    chk("R6 read word1 untouched", r, 32'h0);
    chk("R6 acks by master", 32'(acks - a0), 32'd2);
    chk("R6 final nack", 32'(nacks - n0), 32'd1);
    chk("R4 address read bit", {31'b0, rw}, 32'h1);
  endtask

  task automatic t_nak_strict;
    logic [31:0] c; int w0 = wn, s0 = stops;
    reg_write(5'h04, 32'h0000005A);
    reg_write(5'h08, 32'h00006421);
    reg_write(5'h0C, 32'h0);
    launch(DIV2);
    wait_end("R7 nak run");
    reg_read(5'h00, c);
    chk("R7 error bit", {31'b0, c[3]}, 32'h1);
    chk("R7 auto stop", 32'(stops - s0), 32'd1);
    chk("R7 nothing stored", 32'(wn - w0), 32'd0);
    chk("R7 lines released", {30'b0, dut_scl_low, dut_sda_low}, 32'h0);
  endtask

  task automatic t_nak_ignore;
    logic [31:0] c; int s0 = stops;
    launch(DIV2 | 32'h2);
    wait_end("R8 ignore run");
    reg_read(5'h00, c);
    chk("R8 no error / R7 cleared", {31'b0, c[3]}, 32'h0);
    chk("R8 list completed with stop", 32'(stops - s0), 32'd1);
  endtask

  task automatic t_full_list;
    logic [7:0] exp [10] = '{8'h11,8'h22,8'h33,8'h44,8'h55,8'h66,8'h77,8'h88,8'h11,8'h22};
    int w0 = wn, s0 = stops, i0 = irq_cnt;
    reg_write(5'h04, {24'b0, SLV, 1'b1});
    reg_write(5'h08, 32'h44444421);
    reg_write(5'h0C, 32'h64421644);
    reg_write(5'h10, 32'h44332211);
    reg_write(5'h14, 32'h88776655);
    launch(DIV2);
    wait_end("R3 sixteen slots");
    chk("R5 wrap byte count", 32'(wn - w0), 32'd10);
    for (int i = 0; i < 10; i++) chk("R5 byte order", {24'b0, wlog[w0+i]}, {24'b0, exp[i]});
    chk("R3 both stops", 32'(stops - s0), 32'd2);
    repeat (20) @(negedge clk);
    chk("R3 single irq", 32'(irq_cnt - i0), 32'd1);
  endtask

  task automatic t_hold_persist;
    int w0 = wn, s0 = stops;
    reg_write(5'h08, 32'h00000421);
    reg_write(5'h10, 32'h000000A5);
    launch(DIV2);
    wait_end("R11 run A");
    chk("R11 scl held low", {31'b0, dut_scl_low}, 32'h1);
    chk("R11 no stop", 32'(stops - s0), 32'd0);
    reg_write(5'h08, 32'h00000064);
    reg_write(5'h10, 32'h0000005A);
    launch(DIV2);
    wait_end("R4 run B");
    chk("R4 direction kept", 32'(wn - w0), 32'd2);
    chk("R4 second byte", {24'b0, wlog[w0+1]}, 32'h5A);
    chk("R11 stop after held", 32'(stops - s0), 32'd1);
  endtask

  task automatic t_div(input int d);
    realtime t0, t1; int lim = (d == 0) ? 1 : d;
    reg_write(5'h08, 32'h00000621);
    launch(32'(d) << 12);
    @(posedge scl_bus); t0 = $realtime;
    @(negedge scl_bus); t1 = $realtime;
    chk("R9 scl high time", 32'(int'((t1 - t0) / 1ns)), 32'(20 * lim));
    wait_end("R9 div run");
  endtask

  task automatic t_no_retrigger;
    logic [31:0] c; int i0 = irq_cnt, s0 = starts;
    reg_write(5'h00, DIV2 | 32'h1);
    reg_read(5'h00, c);
    chk("R2 no start on 1->1", {31'b0, c[2]}, 32'h0);
    repeat (200) @(negedge clk);
    chk("R2 no irq on 1->1", 32'(irq_cnt - i0), 32'd0);
    chk("R2 no bus start", 32'(starts - s0), 32'd0);
  endtask

  task automatic t_abort;
    logic [31:0] c; int i0;
    reg_write(5'h08, 32'h44444421);
    reg_write(5'h0C, 32'h64421644);
    launch(32'd20 << 12);
    repeat (400) @(negedge clk);
    i0 = irq_cnt;
    reg_write(5'h00, 32'd20 << 12);
    reg_read(5'h00, c);
    chk("R10 busy cleared", {31'b0, c[2]}, 32'h0);
    chk("R10 lines released", {30'b0, dut_scl_low, dut_sda_low}, 32'h0);
    repeat (500) @(negedge clk);
    chk("R10 no irq", 32'(irq_cnt - i0), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_restart();
    t_nak_strict();
    t_nak_ignore();
    t_full_list();
    t_hold_persist();
    reg_write(5'h04, {24'b0, SLV, 1'b0});
    t_div(5);
    t_div(0);
    t_no_retrigger();
    t_abort();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule